// File: doc/BRIEF.md
# Auxiliary Memory Bank Router

This block decides, for each 16-bit CPU address, which memory resource serves the access. It produces two answers for the same address: one for a read and one for a write. The possible targets are main RAM, auxiliary RAM, the I/O page, the peripheral-card ROM decoder, upper-area RAM and upper-area ROM. The RAM arrays behind these targets, and any display logic, are outside the block.

Six one-bit mode flags steer the routing. Software controls them through the I/O page. A write to a switch offset changes the flag, and the address bit 0 of that write is the new value. A read of a status offset returns the flag in bit 7. One flag selects the bank for the zero and stack pages. A second flag sends reads of the general RAM range to auxiliary RAM, and a third does the same for writes. The other three flags are held and can be read back, but this block does not use them for routing. The upper area follows two enable inputs, one for reads and one for writes, which come from outside the block.

Top module: `aux_bank_router`

## Requirements
- R1: Target codes are MAIN=0, AUX=1, IO=2, SLOT=3, UPRAM=4, ROM=5. Addresses 0x0000–0x01FF go to AUX for both directions while the zero-page flag (index 4) is 1, and to MAIN otherwise.
- R2: For addresses 0x0200–0xBFFF, `rd_target` is AUX while the read-bank flag (index 1) is 1, and `wr_target` is AUX while the write-bank flag (index 2) is 1. Otherwise each is MAIN.
- R3: Addresses 0xC000–0xC0FF give IO for both directions, and addresses 0xC100–0xCFFF give SLOT.
- R4: For addresses 0xD000–0xFFFF, `rd_target` is UPRAM when `upper_rd_en` is 1 and ROM otherwise. `wr_target` is UPRAM when `upper_wr_en` is 1 and ROM otherwise.
- R5: A write (`cpu_wr`) to 0xC000+n, with n from 0x00 to 0x0B, sets flag n>>1 to the value of n[0]. The flag indices are: 0 column store, 1 read bank, 2 write bank, 3 internal card ROM, 4 zero page, 5 card-3 ROM. The new value applies from the next clock cycle.
- R6: Writes to 0xC00C–0xC0FF leave every flag unchanged. Reads of 0xC000–0xC00B also leave every flag unchanged.
- R7: `stat_valid` is 1 only during a read (`cpu_rd`) of a status address. The status addresses are 0xC013 for flag 1, 0xC014 for flag 2, 0xC015 for flag 3, 0xC016 for flag 4, 0xC017 for flag 5 and 0xC018 for flag 0.
- R8: When `stat_valid` is 1, `stat_data` is {flag, 7'b0}. Otherwise `stat_data` is 0.
- R9: A synchronous active-low reset clears all six flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read access this cycle |
| cpu_wr | input | 1 | Write access this cycle |
| upper_rd_en | input | 1 | Upper-area RAM enabled for reads |
| upper_wr_en | input | 1 | Upper-area RAM enabled for writes |
| rd_target | output | 3 | Target that serves a read of `cpu_addr` |
| wr_target | output | 3 | Target that serves a write of `cpu_addr` |
| stat_valid | output | 1 | A status address is being read |
| stat_data | output | 8 | Status byte |

## Verification
The assertions check the following on every cycle:
- the I/O page decode;
- agreement between the read and write answers wherever the active flags give no reason to differ;
- the zeroed low bits of the status byte;
- the one-cycle effect of a set write;
- flag stability when no switch is written;
- the cleared state after reset.

Other behaviours can only be shown by the bench's ordered scenarios:
- the exact pairing of switch offsets to flags;
- the rotated order of the status addresses;
- the range boundaries at 0x01FF/0x0200, 0xBFFF/0xC000, 0xC0FF/0xC100 and 0xCFFF/0xD000;
- whether reads and non-switch writes are ignored.

// File: rtl/aux_bank_pkg.sv
// Package: shared constants, target codes and the status-offset function.
// Assumes a 16-bit address space with the I/O page at 0xC000.
package aux_bank_pkg;

    localparam int ADDR_W    = 16;
    localparam int NUM_FLAGS = 6;
    localparam int OFF_W     = 8;

    localparam logic [ADDR_W-1:0] ZP_END     = 16'h0200;
    localparam logic [ADDR_W-1:0] IO_BASE    = 16'hC000;
    localparam logic [ADDR_W-1:0] SLOT_BASE  = 16'hC100;
    localparam logic [ADDR_W-1:0] UPPER_BASE = 16'hD000;
    localparam logic [OFF_W-1:0]  IO_PAGE    = IO_BASE[ADDR_W-1:OFF_W];
    localparam int                STAT_BASE  = 8'h13;

    typedef enum logic [2:0] {
        TGT_MAIN  = 3'd0,
        TGT_AUX   = 3'd1,
        TGT_IO    = 3'd2,
        TGT_SLOT  = 3'd3,
        TGT_UPRAM = 3'd4,
        TGT_ROM   = 3'd5
    } target_e;

    typedef enum int {
        FL_COLSTORE = 0,
        FL_RDBANK   = 1,
        FL_WRBANK   = 2,
        FL_INTCARD  = 3,
        FL_ZPAGE    = 4,
        FL_CARD3    = 5
    } flag_idx_e;

    // The status offsets list the flags in a rotated order: flag 1 first, flag 0 last.
    function automatic logic [OFF_W-1:0] stat_off(input int idx);
        return OFF_W'(STAT_BASE + ((idx + NUM_FLAGS - 1) % NUM_FLAGS));
    endfunction

endpackage

// File: rtl/sw_flag_file.sv
// Module: sw_flag_file
// Holds the mode flags. A write that hits the I/O page at offset n < 2*NUM_FLAGS
// loads flag n>>1 with n[0]. Assumes wr_hit is already qualified by the I/O page.
module sw_flag_file
    import aux_bank_pkg::*;
#(
    parameter int N_FLAGS = NUM_FLAGS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [OFF_W-1:0]   wr_off,
    output logic [N_FLAGS-1:0] flags
);
    localparam int SW_LIMIT = 2 * N_FLAGS;

    logic sw_sel;

    // Purpose: decide whether this write targets one of the switch offsets.
    always_comb sw_sel = wr_hit && (int'(wr_off) < SW_LIMIT);

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        // Purpose: one flag register, loaded with the low offset bit when its pair is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (sw_sel && (wr_off[OFF_W-1:1] == (OFF_W-1)'(i)))
                flags[i] <= wr_off[0];
        end

        a_r5_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_sel && wr_off == OFF_W'(2*i+1)) |=> flags[i]);
        a_r5_clr_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_sel && wr_off == OFF_W'(2*i)) |=> !flags[i]);
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_sel |=> $stable(flags));
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

endmodule

// File: rtl/stat_readback.sv
// Module: stat_readback
// Selects the flag addressed by a status read and presents it in bit 7.
// Assumes rd_hit is already qualified by the I/O page.
module stat_readback
    import aux_bank_pkg::*;
#(
    parameter int N_FLAGS = NUM_FLAGS
) (
    input  logic               rd_hit,
    input  logic [OFF_W-1:0]   rd_off,
    input  logic [N_FLAGS-1:0] flags,
    output logic               valid,
    output logic [7:0]         data
);
    logic match;
    logic sel_bit;

    // Purpose: scan the status offsets and pick the matching flag.
    always_comb begin
        match   = 1'b0;
        sel_bit = 1'b0;
        for (int i = 0; i < N_FLAGS; i++) begin
            if (rd_off == stat_off(i)) begin
                match   = 1'b1;
                sel_bit = flags[i];
            end
        end
        valid = rd_hit && match;
        data  = valid ? {sel_bit, 7'b0} : 8'h00;
    end

endmodule

// File: rtl/bank_router.sv
// Module: bank_router
// Maps an address to a target for one access direction. Assumes the caller
// supplies the flags and the upper-area enable that apply to that direction.
module bank_router
    import aux_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              zp_aux,
    input  logic              main_aux,
    input  logic              upper_en,
    output target_e           target
);
    // Purpose: compare the address against the region boundaries in ascending order.
    always_comb begin
        if (addr < ZP_END)
            target = zp_aux ? TGT_AUX : TGT_MAIN;
        else if (addr < IO_BASE)
            target = main_aux ? TGT_AUX : TGT_MAIN;
        else if (addr < SLOT_BASE)
            target = TGT_IO;
        else if (addr < UPPER_BASE)
            target = TGT_SLOT;
        else
            target = upper_en ? TGT_UPRAM : TGT_ROM;
    end

endmodule

// File: rtl/aux_bank_router.sv
// Module: aux_bank_router (top)
// Routes reads and writes to memory targets and holds the mode flags.
// Assumes cpu_rd and cpu_wr are not both asserted in the same cycle.
module aux_bank_router
    import aux_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              upper_rd_en,
    input  logic              upper_wr_en,
    output logic [2:0]        rd_target,
    output logic [2:0]        wr_target,
    output logic              stat_valid,
    output logic [7:0]        stat_data
);
    localparam int N_DIR = 2;

    logic [NUM_FLAGS-1:0] flags;
    logic                 io_page;
    logic [N_DIR-1:0]     dir_main_aux;
    logic [N_DIR-1:0]     dir_upper_en;
    target_e              dir_tgt [N_DIR];

    // Purpose: detect an access to the I/O page.
    always_comb io_page = (cpu_addr[ADDR_W-1:OFF_W] == IO_PAGE);

    sw_flag_file #(.N_FLAGS(NUM_FLAGS)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (cpu_wr && io_page),
        .wr_off (cpu_addr[OFF_W-1:0]),
        .flags  (flags)
    );

    stat_readback #(.N_FLAGS(NUM_FLAGS)) i_stat (
        .rd_hit (cpu_rd && io_page),
        .rd_off (cpu_addr[OFF_W-1:0]),
        .flags  (flags),
        .valid  (stat_valid),
        .data   (stat_data)
    );

    // Purpose: collect the flag and enable for each direction (0 = read, 1 = write).
    always_comb begin
        dir_main_aux = {flags[FL_WRBANK], flags[FL_RDBANK]};
        dir_upper_en = {upper_wr_en, upper_rd_en};
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        bank_router i_route (
            .addr     (cpu_addr),
            .zp_aux   (flags[FL_ZPAGE]),
            .main_aux (dir_main_aux[d]),
            .upper_en (dir_upper_en[d]),
            .target   (dir_tgt[d])
        );
    end

    // Purpose: present the read and write answers as plain codes.
    always_comb begin
        rd_target = dir_tgt[0];
        wr_target = dir_tgt[1];
    end

    a_r1_zp_same: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < ZP_END) |-> (rd_target == wr_target));
    a_r2_same_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_RDBANK] == flags[FL_WRBANK]) |-> (rd_target == wr_target) || (cpu_addr >= UPPER_BASE));
    a_r3_io_page: assert property (@(posedge clk) disable iff (!rst_n)
        io_page |-> (rd_target == TGT_IO && wr_target == TGT_IO));
    a_r7_valid_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (cpu_rd && io_page));
    a_r8_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        stat_data[6:0] == 7'b0);

endmodule

// File: tb/test_aux_bank_router.sv
// Bench for aux_bank_router: a walked vector table, then directed reset checks.
module test_aux_bank_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        upper_rd_en = 1'b0;
    logic        upper_wr_en = 1'b0;
    logic [2:0]  rd_target;
    logic [2:0]  wr_target;
    logic        stat_valid;
    logic [7:0]  stat_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aux_bank_router i_aux_bank_router (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .upper_rd_en(upper_rd_en), .upper_wr_en(upper_wr_en),
        .rd_target(rd_target), .wr_target(wr_target),
        .stat_valid(stat_valid), .stat_data(stat_data)
    );

    // {wr, rd, addr, urd, uwr, exp_rd, exp_wr, exp_sv, exp_sd}
    localparam int NV = 40;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0,1'b1,16'h0050,1'b0,1'b0,3'd0,3'd0,1'b0,8'h00}, // R1 main
        {1'b0,1'b1,16'h1000,1'b0,1'b0,3'd0,3'd0,1'b0,8'h00}, // R2 main
        {1'b0,1'b1,16'hC013,1'b0,1'b0,3'd2,3'd2,1'b1,8'h00}, // R7 status 0
        {1'b1,1'b0,16'hC003,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 set rd bank
        {1'b0,1'b1,16'h1000,1'b0,1'b0,3'd1,3'd0,1'b0,8'h00}, // R2 split
        {1'b0,1'b1,16'hC013,1'b0,1'b0,3'd2,3'd2,1'b1,8'h80}, // R8
        {1'b1,1'b0,16'hC005,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 set wr bank
        {1'b0,1'b1,16'h0200,1'b0,1'b0,3'd1,3'd1,1'b0,8'h00}, // R2 low edge
        {1'b0,1'b1,16'h01FF,1'b0,1'b0,3'd0,3'd0,1'b0,8'h00}, // R1 edge main
        {1'b1,1'b0,16'hC009,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 set zp
        {1'b0,1'b1,16'h01FF,1'b0,1'b0,3'd1,3'd1,1'b0,8'h00}, // R1 aux
        {1'b0,1'b0,16'h0000,1'b0,1'b0,3'd1,3'd1,1'b0,8'h00}, // R1 aux
        {1'b1,1'b0,16'hC002,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 clear rd bank
        {1'b0,1'b1,16'hBFFF,1'b0,1'b0,3'd0,3'd1,1'b0,8'h00}, // R2 high edge
        {1'b0,1'b1,16'hC016,1'b0,1'b0,3'd2,3'd2,1'b1,8'h80}, // R7 zp status
        {1'b0,1'b1,16'hC013,1'b0,1'b0,3'd2,3'd2,1'b1,8'h00}, // R5 cleared
        {1'b0,1'b1,16'hC000,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R3 io low
        {1'b0,1'b1,16'hC0FF,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R3 io high
        {1'b0,1'b1,16'hC100,1'b0,1'b0,3'd3,3'd3,1'b0,8'h00}, // R3 slot low
        {1'b0,1'b1,16'hCFFF,1'b0,1'b0,3'd3,3'd3,1'b0,8'h00}, // R3 slot high
        {1'b0,1'b1,16'hD000,1'b1,1'b0,3'd4,3'd5,1'b0,8'h00}, // R4 rd en
        {1'b0,1'b1,16'hFFFF,1'b0,1'b1,3'd5,3'd4,1'b0,8'h00}, // R4 wr en
        {1'b0,1'b1,16'hE000,1'b0,1'b0,3'd5,3'd5,1'b0,8'h00}, // R4 rom
        {1'b1,1'b0,16'hC001,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 set col store
        {1'b0,1'b1,16'hC018,1'b0,1'b0,3'd2,3'd2,1'b1,8'h80}, // R7 col store
        {1'b1,1'b0,16'hC00B,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 set card3
        {1'b0,1'b1,16'hC00A,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R6 read no effect
        {1'b0,1'b1,16'hC017,1'b0,1'b0,3'd2,3'd2,1'b1,8'h80}, // R6 card3 kept
        {1'b1,1'b0,16'hC007,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 set int card
        {1'b0,1'b1,16'hC015,1'b0,1'b0,3'd2,3'd2,1'b1,8'h80}, // R7 int card
        {1'b1,1'b0,16'hC00C,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R6 non-switch write
        {1'b1,1'b0,16'hC016,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R6/R7 write to status
        {1'b0,1'b1,16'hC016,1'b0,1'b0,3'd2,3'd2,1'b1,8'h80}, // R6 zp kept
        {1'b0,1'b1,16'hC014,1'b0,1'b0,3'd2,3'd2,1'b1,8'h80}, // R6 wr bank kept
        {1'b0,1'b1,16'hC019,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R7 non-status
        {1'b0,1'b1,16'hC012,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R7 non-status
        {1'b1,1'b0,16'hC004,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 clear wr bank
        {1'b0,1'b1,16'hC014,1'b0,1'b0,3'd2,3'd2,1'b1,8'h00}, // R8 cleared
        {1'b1,1'b0,16'hC008,1'b0,1'b0,3'd2,3'd2,1'b0,8'h00}, // R5 clear zp
        {1'b0,1'b1,16'h0300,1'b0,1'b0,3'd0,3'd0,1'b0,8'h00}  // R2 main again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic wr, input logic rd, input logic [15:0] a,
                         input logic urd, input logic uwr);
        @(negedge clk);
        cpu_wr = wr; cpu_rd = rd; cpu_addr = a; upper_rd_en = urd; upper_wr_en = uwr;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        apply(1'b0, 1'b1, 16'hC016, 1'b0, 1'b0);
        check("R9 zp status after reset", {24'h0, stat_data}, 32'h00);
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][34], VEC[v][33], VEC[v][32:17], VEC[v][16], VEC[v][15]);
            check($sformatf("vec %0d rd_target (R1-R4 table)", v), {29'h0, rd_target}, {29'h0, VEC[v][14:12]});
            check($sformatf("vec %0d wr_target (R1-R4 table)", v), {29'h0, wr_target}, {29'h0, VEC[v][11:9]});
            check($sformatf("vec %0d stat_valid R7", v), {31'h0, stat_valid}, {31'h0, VEC[v][8]});
            check($sformatf("vec %0d stat_data R8", v), {24'h0, stat_data}, {24'h0, VEC[v][7:0]});
        end
        // Directed: set several flags, then reset clears all (R9)
        apply(1'b1, 1'b0, 16'hC009, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 16'hC003, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 16'h0100, 1'b0, 1'b0);
        check("R1 zp aux before reset", {29'h0, rd_target}, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 1'b1, 16'h0100, 1'b0, 1'b0);
        check("R9 zp routing after reset", {29'h0, rd_target}, 32'd0);
        apply(1'b0, 1'b1, 16'h4000, 1'b0, 1'b0);
        check("R9 rd bank routing after reset", {29'h0, rd_target}, 32'd0);
        for (int s = 16'hC013; s <= 16'hC018; s++) begin
            apply(1'b0, 1'b1, 16'(s), 1'b0, 1'b0);
            check("R9 status cleared", {23'h0, stat_valid, stat_data}, 32'h100);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule